// File: doc/BRIEF.md
# 10b/8b Symbol Decoder with Running-Disparity Check

This block turns a stream of already aligned 10-bit line symbols back into bytes. Each symbol comes with a one-cycle strobe. The symbol is used directly as the address of a 1024-entry lookup table. One read returns the decoded byte, a data/control flag, the running-disparity states in which the symbol is legal, and whether it has more ones than zeros, fewer, or an equal count. A register pair after the table presents the result one byte-clock later. The same edge also advances a running-disparity register.

The table content is generated when the design elaborates, from the forward coding rules: the 5-bit to 6-bit sub-block, the 3-bit to 4-bit sub-block, and the 12 control characters. There is therefore no hand-entered list to maintain. A symbol that no character encodes to raises a code error. A legal symbol that arrives in the wrong disparity state raises a disparity error. After a disparity error the tracker realigns itself to the symbol it actually received.

Top module: `sym10_decoder`

## Requirements
- R1: Bit 9 of `sym_in` is the first line bit (a) and bit 0 is the last (j). A data symbol decodes to a byte whose bits [4:0] are the 5-bit sub-block value and bits [7:5] are the 3-bit sub-block value, with `is_ctrl` low. For example, 10'b1010110001 at negative disparity decodes to 8'hFF.
- R2: The 12 control symbols decode with `is_ctrl` high. These are the eight 8'hxC/28-group codes (x = 0..7) and 8'hF7, 8'hFB, 8'hFD, 8'hFE. Their byte values appear on `byte_out`.
- R3: Where a character has two line forms (one per disparity state), both forms decode to the same byte and flag.
- R4: A symbol that is no legal code word sets `code_err` and forces `byte_out` to 0, `is_ctrl` to 0 and `disp_err` to 0. It leaves `rd_pos` unchanged.
- R5: A legal symbol that is not legal in the current disparity state sets `disp_err`. Its byte and flag are still decoded.
- R6: `rd_pos` is 0 for negative and 1 for positive. It starts at 0. After an error-free symbol it flips if the symbol has six or four ones, and holds if the symbol has five.
- R7: After a disparity error, `rd_pos` takes the state the symbol ends in when coded from the state where it is legal. An unbalanced symbol therefore leaves `rd_pos` at 1 for six ones and 0 for four, and a balanced one inverts it.
- R8: The outputs and `rd_pos` change on the first rising edge at which `sym_valid` is high, and hold unchanged at every edge where it is low.
- R9: Synchronous `rst` sets `byte_out`, `is_ctrl`, `code_err`, `disp_err` and `rd_pos` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_in | input | 10 | Received symbol, bit 9 first on the line |
| sym_valid | input | 1 | Strobe: `sym_in` holds a symbol this cycle |
| byte_out | output | 8 | Decoded byte |
| is_ctrl | output | 1 | High for a control character |
| rd_pos | output | 1 | Running disparity after the last symbol (1 = positive) |
| code_err | output | 1 | Last symbol was not a code word |
| disp_err | output | 1 | Last symbol was illegal in the expected disparity state |

## Verification
The stimulus stream runs through both line forms of the same characters. This includes the seventh 3-bit code in its alternate shape, which a table built with the wrong substitution rule would decode as a code error or as a different byte. Two disparity errors are injected: one with an unbalanced symbol and one with a balanced symbol that is legal only in the other state. A tracker that merely holds or merely flips on an error would then disagree on the next clean symbol. Invalid patterns, including one with five ones, must clear the byte and leave the disparity untouched. Further checks confirm that an idle strobe freezes every output and that reset in the middle of the stream returns the disparity to negative.

// File: rtl/sym10_pkg.sv
package sym10_pkg;

  localparam int SYM_W   = 10;
  localparam int BYTE_W  = 8;
  localparam int LO_W    = 5;
  localparam int HI_W    = BYTE_W - LO_W;
  localparam int SIX_W   = 6;
  localparam int FOUR_W  = SYM_W - SIX_W;
  localparam int N_DATA  = 1 << BYTE_W;
  localparam int N_CTRL  = 12;
  localparam int N_CHAR  = N_DATA + N_CTRL;
  localparam int BAL_ONES = SYM_W / 2;

  typedef enum logic [1:0] {
    CLS_NEUTRAL = 2'b00,
    CLS_PLUS    = 2'b01,
    CLS_MINUS   = 2'b10
  } sym_cls_e;

  typedef struct packed {
    logic              legal_neg;
    logic              legal_pos;
    logic              ctrl;
    logic [BYTE_W-1:0] value;
    sym_cls_e          cls;
  } rom_entry_t;

  // 6-bit sub-block as sent from negative disparity
  function automatic logic [SIX_W-1:0] six_from_neg(input logic [LO_W-1:0] x);
    logic [SIX_W-1:0] c;
    case (x)
      5'd0:  c = 6'b100111;  5'd1:  c = 6'b011101;
      5'd2:  c = 6'b101101;  5'd3:  c = 6'b110001;
      5'd4:  c = 6'b110101;  5'd5:  c = 6'b101001;
      5'd6:  c = 6'b011001;  5'd7:  c = 6'b111000;
      5'd8:  c = 6'b111001;  5'd9:  c = 6'b100101;
      5'd10: c = 6'b010101;  5'd11: c = 6'b110100;
      5'd12: c = 6'b001101;  5'd13: c = 6'b101100;
      5'd14: c = 6'b011100;  5'd15: c = 6'b010111;
      5'd16: c = 6'b011011;  5'd17: c = 6'b100011;
      5'd18: c = 6'b010011;  5'd19: c = 6'b110010;
      5'd20: c = 6'b001011;  5'd21: c = 6'b101010;
      5'd22: c = 6'b011010;  5'd23: c = 6'b111010;
      5'd24: c = 6'b110011;  5'd25: c = 6'b100110;
      5'd26: c = 6'b010110;  5'd27: c = 6'b110110;
      5'd28: c = 6'b001110;  5'd29: c = 6'b101110;
      5'd30: c = 6'b011110;  default: c = 6'b101011;
    endcase
    return c;
  endfunction

  function automatic logic [SIX_W-1:0] six_code(input logic [LO_W-1:0] x,
                                                 input logic k, input logic rd);
    logic [SIX_W-1:0] base;
    base = (k && x == 5'd28) ? 6'b001111 : six_from_neg(x);
    if (rd && (($countones(base) != SIX_W / 2) || (x == 5'd7 && !k)))
      base = ~base;
    return base;
  endfunction

  function automatic logic [FOUR_W-1:0] four_code(input logic [HI_W-1:0] y,
                                                   input logic [LO_W-1:0] x,
                                                   input logic k, input logic rd_mid);
    logic [FOUR_W-1:0] c;
    logic alt;
    if (k && x == 5'd28) begin
      case (y)
        3'd0: c = 4'b1011;  3'd1: c = 4'b0110;
        3'd2: c = 4'b1010;  3'd3: c = 4'b1100;
        3'd4: c = 4'b1101;  3'd5: c = 4'b0101;
        3'd6: c = 4'b1001;  default: c = 4'b0111;
      endcase
      if (rd_mid) c = ~c;
    end else if (y == 3'd7) begin
      alt = k || (!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20))
              || (rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14));
      if (alt) c = rd_mid ? 4'b1000 : 4'b0111;
      else     c = rd_mid ? 4'b0001 : 4'b1110;
    end else begin
      case (y)
        3'd0: c = 4'b1011;  3'd1: c = 4'b1001;
        3'd2: c = 4'b0101;  3'd3: c = 4'b1100;
        3'd4: c = 4'b1101;  3'd5: c = 4'b1010;
        default: c = 4'b0110;
      endcase
      if (rd_mid && (y == 3'd0 || y == 3'd3 || y == 3'd4)) c = ~c;
    end
    return c;
  endfunction

  function automatic logic [SYM_W-1:0] encode_char(input logic [BYTE_W-1:0] b,
                                                    input logic k, input logic rd);
    logic [SIX_W-1:0] s;
    logic rd_mid;
    s      = six_code(b[LO_W-1:0], k, rd);
    rd_mid = rd ^ ($countones(s) != SIX_W / 2);
    return {s, four_code(b[BYTE_W-1:LO_W], b[LO_W-1:0], k, rd_mid)};
  endfunction

  // Index i < N_DATA is the data byte i; above that, the 12 control bytes
  function automatic logic [BYTE_W-1:0] char_byte(input int i);
    int c;
    if (i < N_DATA) return BYTE_W'(i);
    c = i - N_DATA;
    if (c < 8) return {3'(c), 5'd28};
    case (c)
      8:       return 8'hF7;
      9:       return 8'hFB;
      10:      return 8'hFD;
      default: return 8'hFE;
    endcase
  endfunction

  function automatic sym_cls_e class_of(input logic [SYM_W-1:0] s);
    int n;
    n = $countones(s);
    if (n > BAL_ONES) return CLS_PLUS;
    if (n < BAL_ONES) return CLS_MINUS;
    return CLS_NEUTRAL;
  endfunction

endpackage

// File: rtl/sym10_code_rom.sv
module sym10_code_rom
  import sym10_pkg::*;
#(
  parameter int AW = SYM_W
) (
  input  logic [AW-1:0] addr,
  output rom_entry_t    entry
);
  localparam int DEPTH = 1 << AW;

  rom_entry_t rom [DEPTH];

  // Content is generated from the forward coding rules, once per
  // character and per starting disparity.
  initial begin
    for (int a = 0; a < DEPTH; a++) rom[a] = '0;
    for (int i = 0; i < N_CHAR; i++) begin
      for (int r = 0; r < 2; r++) begin
        logic [SYM_W-1:0] code;
        logic [BYTE_W-1:0] b;
        logic k;
        b    = char_byte(i);
        k    = (i >= N_DATA);
        code = encode_char(b, k, r[0]);
        rom[code].value = b;
        rom[code].ctrl  = k;
        rom[code].cls   = class_of(code);
        if (r == 0) rom[code].legal_neg = 1'b1;
        else        rom[code].legal_pos = 1'b1;
      end
    end
  end

  assign entry = rom[addr];

endmodule

// File: rtl/sym10_rd_track.sv
module sym10_rd_track
  import sym10_pkg::*;
#(
  parameter bit RD_INIT = 1'b0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     strobe,
  input  logic     legal_neg,
  input  logic     legal_pos,
  input  sym_cls_e cls,
  output logic     rd_q,
  output logic     is_code,
  output logic     mismatch
);
  logic legal_here;
  logic unbalanced;
  logic rd_d;

  always_comb begin
    is_code    = legal_neg | legal_pos;
    legal_here = rd_q ? legal_pos : legal_neg;
    mismatch   = is_code & ~legal_here;
    unbalanced = (cls != CLS_NEUTRAL);
    // On mismatch the symbol started from the other state
    rd_d       = rd_q ^ mismatch ^ unbalanced;
  end

  always_ff @(posedge clk) begin
    if (rst)                   rd_q <= RD_INIT;
    else if (strobe && is_code) rd_q <= rd_d;
  end

endmodule

// File: rtl/sym10_out_stage.sv
module sym10_out_stage
  import sym10_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic          is_code,
  input  logic          mismatch,
  input  logic [DW-1:0] value,
  input  logic          ctrl,
  output logic [DW-1:0] data_q,
  output logic          ctrl_q,
  output logic          code_err_q,
  output logic          disp_err_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q     <= '0;
      ctrl_q     <= 1'b0;
      code_err_q <= 1'b0;
      disp_err_q <= 1'b0;
    end else if (strobe) begin
      if (is_code) begin
        data_q     <= value;
        ctrl_q     <= ctrl;
        code_err_q <= 1'b0;
        disp_err_q <= mismatch;
      end else begin
        data_q     <= '0;
        ctrl_q     <= 1'b0;
        code_err_q <= 1'b1;
        disp_err_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sym10_decoder.sv
module sym10_decoder
  import sym10_pkg::*;
#(
  parameter bit RD_INIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SYM_W-1:0]  sym_in,
  input  logic              sym_valid,
  output logic [BYTE_W-1:0] byte_out,
  output logic              is_ctrl,
  output logic              rd_pos,
  output logic              code_err,
  output logic              disp_err
);
  rom_entry_t entry;
  logic       is_code;
  logic       mismatch;

  sym10_code_rom #(.AW(SYM_W)) u_rom (
    .addr  (sym_in),
    .entry (entry)
  );

  sym10_rd_track #(.RD_INIT(RD_INIT)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .strobe    (sym_valid),
    .legal_neg (entry.legal_neg),
    .legal_pos (entry.legal_pos),
    .cls       (entry.cls),
    .rd_q      (rd_pos),
    .is_code   (is_code),
    .mismatch  (mismatch)
  );

  sym10_out_stage #(.DW(BYTE_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .strobe     (sym_valid),
    .is_code    (is_code),
    .mismatch   (mismatch),
    .value      (entry.value),
    .ctrl       (entry.ctrl),
    .data_q     (byte_out),
    .ctrl_q     (is_ctrl),
    .code_err_q (code_err),
    .disp_err_q (disp_err)
  );

endmodule

// File: rtl/sym10_decoder_chk.sv
module sym10_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic [9:0] sym_in,
  input logic       sym_valid,
  input logic [7:0] byte_out,
  input logic       is_ctrl,
  input logic       rd_pos,
  input logic       code_err,
  input logic       disp_err
);
  AST_BAD_CODE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    code_err |-> (byte_out == 8'h00 && !is_ctrl && !disp_err)); // R4

  AST_BAD_CODE_KEEPS_RD: assert property (@(posedge clk) disable iff (rst)
    sym_valid |=> (!code_err || rd_pos == $past(rd_pos))); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !sym_valid |=> $stable({byte_out, is_ctrl, rd_pos, code_err, disp_err})); // R8

  AST_BALANCED_KEEPS_RD: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && $countones(sym_in) == 5)
      |=> (code_err || disp_err || rd_pos == $past(rd_pos))); // R6

  AST_UNBALANCED_FLIPS_RD: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && $countones(sym_in) != 5)
      |=> (code_err || disp_err || rd_pos != $past(rd_pos))); // R6

  AST_RESYNC_FOLLOWS_SYMBOL: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && $countones(sym_in) != 5)
      |=> (!disp_err || rd_pos == ($countones($past(sym_in)) > 5))); // R7
endmodule

bind sym10_decoder sym10_decoder_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .sym_in    (sym_in),
  .sym_valid (sym_valid),
  .byte_out  (byte_out),
  .is_ctrl   (is_ctrl),
  .rd_pos    (rd_pos),
  .code_err  (code_err),
  .disp_err  (disp_err)
);

// File: tb/tb_sym10_decoder.sv
module tb_sym10_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] sym_in = '0;
  logic       sym_valid = 1'b0;
  logic [7:0] byte_out;
  logic       is_ctrl, rd_pos, code_err, disp_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  sym10_decoder dut (
    .clk(clk), .rst(rst), .sym_in(sym_in), .sym_valid(sym_valid),
    .byte_out(byte_out), .is_ctrl(is_ctrl), .rd_pos(rd_pos),
    .code_err(code_err), .disp_err(disp_err)
  );

  // {symbol, byte, ctrl, code_err, disp_err, rd_pos after}, applied in order
  localparam logic [21:0] VEC [18] = '{
    {10'b1010110001, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 FF at negative
    {10'b0011111010, 8'hBC, 1'b1, 1'b0, 1'b0, 1'b1}, // R2 R3 negative form
    {10'b1100000101, 8'hBC, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 R3 positive form
    {10'b1001110100, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
    {10'b1010101010, 8'hB5, 1'b0, 1'b0, 1'b0, 1'b0},
    {10'b1110001110, 8'hE7, 1'b0, 1'b0, 1'b0, 1'b1}, // R3
    {10'b0001110001, 8'hE7, 1'b0, 1'b0, 1'b0, 1'b0}, // R3
    {10'b1000110111, 8'hF1, 1'b0, 1'b0, 1'b0, 1'b1}, // alternate 7, negative
    {10'b1101001000, 8'hEB, 1'b0, 1'b0, 1'b0, 1'b0}, // alternate 7, positive
    {10'b0011111000, 8'hFC, 1'b1, 1'b0, 1'b0, 1'b0},
    {10'b1110101000, 8'hF7, 1'b1, 1'b0, 1'b0, 1'b0},
    {10'b1101011001, 8'h24, 1'b0, 1'b0, 1'b0, 1'b1},
    {10'b1001000101, 8'h50, 1'b0, 1'b0, 1'b0, 1'b0},
    {10'b0000000000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0}, // R4
    {10'b1100000101, 8'hBC, 1'b1, 1'b0, 1'b1, 1'b0}, // R5 R7 unbalanced
    {10'b0001111001, 8'h27, 1'b0, 1'b0, 1'b1, 1'b1}, // R5 R7 balanced
    {10'b0110001011, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 next clean symbol
    {10'b1111100000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1}  // R4 five ones, invalid
  };

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic send(input logic [9:0] s);
    @(negedge clk);
    sym_in    = s;
    sym_valid = 1'b1;
    @(negedge clk);
    sym_valid = 1'b0;
  endtask

  task automatic check_all(input string tag, input logic [7:0] b, input logic k,
                           input logic ce, input logic de, input logic rd);
    check(tag, "byte_out", 32'(byte_out), 32'(b));
    check(tag, "is_ctrl", 32'(is_ctrl), 32'(k));
    check(tag, "code_err", 32'(code_err), 32'(ce));
    check(tag, "disp_err", 32'(disp_err), 32'(de));
    check(tag, "rd_pos", 32'(rd_pos), 32'(rd));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_all("R9", 8'h00, 1'b0, 1'b0, 1'b0, 1'b0); // R6 starts negative

    for (int i = 0; i < 18; i++) begin
      logic [21:0] v;
      string tg;
      v = VEC[i];
      send(v[21:12]);
      if (v[2])      tg = "R4";
      else if (v[1]) tg = "R5";
      else if (v[3]) tg = "R2";
      else           tg = "R1";
      check(tg, "byte_out", 32'(byte_out), 32'(v[11:4]));
      check(tg, "is_ctrl", 32'(is_ctrl), 32'(v[3]));
      check("R4", "code_err", 32'(code_err), 32'(v[2]));
      check("R5", "disp_err", 32'(disp_err), 32'(v[1]));
      check(v[1] ? "R7" : "R6", "rd_pos", 32'(rd_pos), 32'(v[0]));
    end

    // R8: a legal symbol without strobe changes nothing
    @(negedge clk);
    sym_in = 10'b1100000101;
    repeat (3) @(negedge clk);
    check_all("R8", 8'h00, 1'b0, 1'b1, 1'b0, 1'b1);

    // R8: one edge with strobe is enough for the result to appear
    sym_valid = 1'b1;
    @(negedge clk);
    sym_valid = 1'b0;
    check_all("R8", 8'hBC, 1'b1, 1'b0, 1'b0, 1'b0);

    // R9: reset in mid-stream after disparity went positive
    send(10'b1101011001);
    check("R6", "rd_pos", 32'(rd_pos), 32'd1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_all("R9", 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);

    // R1: after reset the reference symbol decodes again at negative
    send(10'b1010110001);
    check_all("R1", 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule